// File: doc/BRIEF.md
# Boundary-Scan Pin Register

This block is the boundary-scan register for a row of I/O pins. Every pin carries three scan cells, one each for the pad input, the pad output data and the pad output enable. Each cell has a capture/shift stage and a separate update stage. All cells link into one serial path from `scan_in` to `scan_out`. A test access port controller, outside this block, supplies the capture, shift and update strobes. It also supplies two decoded instruction flags: one for driving pins from the register (external test) and one for sampling and preloading.

On the parallel side the block sits between the core and the pad buffers. With the external-test flag low, the core's output data and enable pass straight to the pad. With the flag high, the pad is driven from the update stages of the output and control cells. The pad input always reaches the core directly, whatever the mode. The sample/preload flag lets the current pin state be captured and shifted out. It also lets update stages be loaded in advance, so that entering external test drives known values at once.

Top module: `bscan_io_chain`

## Requirements
- R1: A synchronous active-low reset clears every capture/shift stage and every update stage. Just after reset, `scan_out` is 0, and selecting external test drives `pad_out` and `pad_oe` to all zeros.
- R2: On a clock edge where `capture_en` is high and either mode flag is set, the cell for pin p at chain index 3p loads `pad_in[p]`, index 3p+1 loads `core_out[p]`, and index 3p+2 loads `core_oe[p]`.
- R3: On a clock edge where `shift_en` is high (and `capture_en` is low) with either mode flag set, each cell takes the value of the cell at the next higher index, and the highest index takes `scan_in`. `scan_out` shows index 0 (the input cell of pin 0), so captured bits leave in index order.
- R4: The serial path is exactly 3×NUM_PINS cells long. A word shifted in is shifted back out unchanged after that many further shifts.
- R5: Update stages load from the capture/shift stages only on an edge with `update_en` high and a mode flag set. During external test, shifting without an update leaves `pad_out` and `pad_oe` unchanged.
- R6: While `extest_mode` is high, `pad_out[p]` equals the update stage at index 3p+1 and `pad_oe[p]` equals the update stage at index 3p+2, independent of `core_out` and `core_oe`.
- R7: While `extest_mode` is low, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`.
- R8: `core_in` equals `pad_in` in every mode.
- R9: With both mode flags low, all three strobes have no effect: the serial path contents and the update stages are kept.
- R10: Under sample/preload, shifting in a word and issuing an update leaves the pads under core control. A later switch to external test then drives the preloaded output and enable values without any further strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_in | input | 1 | Serial data into the highest-index cell |
| scan_out | output | 1 | Serial data from cell index 0 |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| extest_mode | input | 1 | External-test instruction decoded |
| sample_mode | input | 1 | Sample/preload instruction decoded |
| core_out | input | NUM_PINS | Output data from core logic |
| core_oe | input | NUM_PINS | Output enable from core logic |
| core_in | output | NUM_PINS | Pad input value to core logic |
| pad_in | input | NUM_PINS | Value received from the pad buffers |
| pad_out | output | NUM_PINS | Output data to the pad buffers |
| pad_oe | output | NUM_PINS | Output enable to the pad buffers |

## Verification
The hardest state to reach from the ports is one where the update stages hold a value that differs from both the core's drive and the current shift contents. Only then can the separation between the two stages be seen at the pads. The stimulus preloads one word under sample/preload and enters external test to show it on the pads. It then shifts a second word without an update and confirms the pads have not moved. Finally it issues all three strobes with no mode selected, and shows by switching modes and shifting out that neither stage was touched.

// File: rtl/bscan_pkg.sv
// Package: shared constants and helpers for the boundary-scan pin register.
// Assumes every pin contributes exactly three cells in a fixed role order.
package bscan_pkg;

    localparam int CELLS_PER_PIN = 3;

    // Role of a cell inside one pin; the value is its offset in the chain.
    typedef enum logic [1:0] {
        ROLE_IN  = 2'd0,
        ROLE_OUT = 2'd1,
        ROLE_CTL = 2'd2
    } cell_role_e;

    // Chain index of a given cell role of a given pin (index 0 next to scan_out).
    function automatic int cell_index(input int pin, input cell_role_e role);
        return pin * CELLS_PER_PIN + int'(role);
    endfunction

endpackage

// File: rtl/bscan_strobe_gate.sv
// Module: qualifies the controller strobes with the decoded instruction.
// Assumes the strobes and mode flags are already synchronous to clk.
module bscan_strobe_gate (
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    input  logic extest_mode,
    input  logic sample_mode,
    output logic cap_g,
    output logic shf_g,
    output logic upd_g,
    output logic drive_sel
);

    logic reg_sel;

    // Gate every strobe with "this register is the selected data register".
    always_comb begin
        reg_sel   = extest_mode | sample_mode;
        cap_g     = capture_en & reg_sel;
        shf_g     = shift_en & reg_sel & ~capture_en;
        upd_g     = update_en & reg_sel;
        drive_sel = extest_mode;
    end

endmodule

// File: rtl/bscan_cell.sv
// Module: one boundary-scan cell with a capture/shift stage and an update stage.
// Assumes capture and shift are never both active (capture wins if they are).
module bscan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic shf,
    input  logic upd,
    input  logic par_in,
    input  logic ser_in,
    output logic ser_out,
    output logic upd_q
);

    logic sh_q;

    // Capture/shift stage: parallel load on capture, serial move on shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= 1'b0;
        else if (cap)
            sh_q <= par_in;
        else if (shf)
            sh_q <= ser_in;
    end

    // Update stage: copies the shift stage only on the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upd_q <= 1'b0;
        else if (upd)
            upd_q <= sh_q;
    end

    assign ser_out = sh_q;

endmodule

// File: rtl/bscan_pin.sv
// Module: the three cells of one pin plus the pad drive multiplexer.
// Assumes ser_in comes from the next pin (toward scan_in) and ser_out
// feeds the previous pin (toward scan_out).
module bscan_pin
    import bscan_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap,
    input  logic                     shf,
    input  logic                     upd,
    input  logic                     drive_sel,
    input  logic                     ser_in,
    output logic                     ser_out,
    input  logic                     core_out,
    input  logic                     core_oe,
    input  logic                     pad_in,
    output logic                     core_in,
    output logic                     pad_out,
    output logic                     pad_oe,
    output logic [CELLS_PER_PIN-1:0] sh_vec
);

    logic [CELLS_PER_PIN-1:0] par_vec;
    logic [CELLS_PER_PIN-1:0] upd_vec;

    // Parallel sources in role order.
    always_comb begin
        par_vec[ROLE_IN]  = pad_in;
        par_vec[ROLE_OUT] = core_out;
        par_vec[ROLE_CTL] = core_oe;
    end

    for (genvar c = 0; c < CELLS_PER_PIN; c++) begin : g_cell
        logic link_in;
        if (c == CELLS_PER_PIN - 1) begin : g_top
            assign link_in = ser_in;
        end else begin : g_mid
            assign link_in = sh_vec[c+1];
        end
        bscan_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap     (cap),
            .shf     (shf),
            .upd     (upd),
            .par_in  (par_vec[c]),
            .ser_in  (link_in),
            .ser_out (sh_vec[c]),
            .upd_q   (upd_vec[c])
        );
    end

    // Pad drive: update stages under external test, core otherwise.
    always_comb begin
        pad_out = drive_sel ? upd_vec[ROLE_OUT] : core_out;
        pad_oe  = drive_sel ? upd_vec[ROLE_CTL] : core_oe;
        core_in = pad_in;
    end

    assign ser_out = sh_vec[ROLE_IN];

endmodule

// File: rtl/bscan_io_chain.sv
// Module: boundary-scan register for NUM_PINS pins, three cells per pin,
// chained from scan_in (last pin's control cell) to scan_out (pin 0 input cell).
// Assumes the strobes and mode flags come from a TAP controller on clk.
module bscan_io_chain
    import bscan_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scan_in,
    output logic                scan_out,
    input  logic                capture_en,
    input  logic                shift_en,
    input  logic                update_en,
    input  logic                extest_mode,
    input  logic                sample_mode,
    input  logic [NUM_PINS-1:0] core_out,
    input  logic [NUM_PINS-1:0] core_oe,
    output logic [NUM_PINS-1:0] core_in,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    localparam int CHAIN_LEN = NUM_PINS * CELLS_PER_PIN;

    logic                 cap_g;
    logic                 shf_g;
    logic                 upd_g;
    logic                 drive_sel;
    logic [NUM_PINS-1:0]  pin_ser_out;
    logic [CHAIN_LEN-1:0] chain_q;

    bscan_strobe_gate u_gate (
        .capture_en  (capture_en),
        .shift_en    (shift_en),
        .update_en   (update_en),
        .extest_mode (extest_mode),
        .sample_mode (sample_mode),
        .cap_g       (cap_g),
        .shf_g       (shf_g),
        .upd_g       (upd_g),
        .drive_sel   (drive_sel)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic pin_link;
        if (p == NUM_PINS - 1) begin : g_last
            assign pin_link = scan_in;
        end else begin : g_inner
            assign pin_link = pin_ser_out[p+1];
        end
        bscan_pin u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .cap       (cap_g),
            .shf       (shf_g),
            .upd       (upd_g),
            .drive_sel (drive_sel),
            .ser_in    (pin_link),
            .ser_out   (pin_ser_out[p]),
            .core_out  (core_out[p]),
            .core_oe   (core_oe[p]),
            .pad_in    (pad_in[p]),
            .core_in   (core_in[p]),
            .pad_out   (pad_out[p]),
            .pad_oe    (pad_oe[p]),
            .sh_vec    (chain_q[p*CELLS_PER_PIN +: CELLS_PER_PIN])
        );
    end

    assign scan_out = pin_ser_out[0];

endmodule

// File: rtl/bscan_io_chain_chk.sv
// Checker: temporal properties of the boundary-scan pin register,
// bound to every instance of bscan_io_chain.
module bscan_io_chain_chk #(
    parameter int NUM_PINS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scan_in,
    input logic                  capture_en,
    input logic                  shift_en,
    input logic                  update_en,
    input logic                  extest_mode,
    input logic                  sample_mode,
    input logic [NUM_PINS-1:0]   core_out,
    input logic [NUM_PINS-1:0]   core_oe,
    input logic [NUM_PINS-1:0]   pad_in,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [3*NUM_PINS-1:0] chain_q
);

    localparam int LEN = 3 * NUM_PINS;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> chain_q == '0);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_cap
        // R2
        capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (capture_en && (sample_mode || extest_mode)) |=>
            (chain_q[3*p]   == $past(pad_in[p]) &&
             chain_q[3*p+1] == $past(core_out[p]) &&
             chain_q[3*p+2] == $past(core_oe[p])));
    end

    // R3
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !capture_en && (sample_mode || extest_mode)) |=>
        chain_q == {$past(scan_in), $past(chain_q[LEN-1:1])});

    // R5
    pads_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (extest_mode && !update_en) |=>
        (!extest_mode || ($stable(pad_out) && $stable(pad_oe))));

    // R7
    core_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !extest_mode |-> (pad_out == core_out && pad_oe == core_oe));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!extest_mode && !sample_mode) |=> $stable(chain_q));

endmodule

bind bscan_io_chain bscan_io_chain_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_in     (scan_in),
    .capture_en  (capture_en),
    .shift_en    (shift_en),
    .update_en   (update_en),
    .extest_mode (extest_mode),
    .sample_mode (sample_mode),
    .core_out    (core_out),
    .core_oe     (core_oe),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .chain_q     (chain_q)
);

// File: tb/bscan_io_chain_test.sv
// Bench: vector table for pass-through and capture, then directed tests.
module bscan_io_chain_test;

    localparam int N = 4;
    localparam int L = 3 * N;
    localparam int NV = 6;

    // Each vector: {pad_in, core_oe, core_out}
    localparam logic [L-1:0] VEC [NV] = '{
        12'h000, 12'hFFF, 12'hA5C, 12'h3C9, 12'h516, 12'hE81
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scan_in = 1'b0;
    logic         scan_out;
    logic         capture_en = 1'b0;
    logic         shift_en = 1'b0;
    logic         update_en = 1'b0;
    logic         extest_mode = 1'b0;
    logic         sample_mode = 1'b0;
    logic [N-1:0] core_out = '0;
    logic [N-1:0] core_oe = '0;
    logic [N-1:0] core_in;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_oe;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    bscan_io_chain #(.NUM_PINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .scan_out(scan_out),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .extest_mode(extest_mode), .sample_mode(sample_mode),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe_capture();
        capture_en = 1'b1; tick(); capture_en = 1'b0;
    endtask

    task automatic strobe_update();
        update_en = 1'b1; tick(); update_en = 1'b0;
    endtask

    // Shift L bits in (bit 0 first); return bits seen on scan_out (index order).
    task automatic shift_word(input logic [L-1:0] din, output logic [L-1:0] dout);
        shift_en = 1'b1;
        for (int i = 0; i < L; i++) begin
            dout[i] = scan_out;
            scan_in = din[i];
            tick();
        end
        shift_en = 1'b0;
        scan_in  = 1'b0;
    endtask

    function automatic logic [L-1:0] expect_cap(input logic [N-1:0] pi,
                                                 input logic [N-1:0] oe,
                                                 input logic [N-1:0] co);
        logic [L-1:0] v;
        for (int p = 0; p < N; p++) begin
            v[3*p]   = pi[p];
            v[3*p+1] = co[p];
            v[3*p+2] = oe[p];
        end
        return v;
    endfunction

    function automatic logic [N-1:0] out_bits(input logic [L-1:0] v);
        logic [N-1:0] r;
        for (int p = 0; p < N; p++) r[p] = v[3*p+1];
        return r;
    endfunction

    function automatic logic [N-1:0] oe_bits(input logic [L-1:0] v);
        logic [N-1:0] r;
        for (int p = 0; p < N; p++) r[p] = v[3*p+2];
        return r;
    endfunction

    initial begin : watchdog
        #(4 * 100000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [L-1:0] got;
        logic [L-1:0] pre_w;
        logic [L-1:0] new_w;
        pre_w = 12'h6B3;
        new_w = 12'h94E;

        // R1: reset state
        repeat (3) tick();
        check("R1 scan_out in reset", 32'(scan_out), 32'h0);
        rst_n = 1'b1;
        tick();
        sample_mode = 1'b1;
        shift_word('0, got);
        check("R1 chain cleared", 32'(got), 32'h0);
        sample_mode = 1'b0;
        extest_mode = 1'b1;
        core_out = 4'hF; core_oe = 4'hF;
        #1;
        check("R1 update pad_out cleared", 32'(pad_out), 32'h0);
        check("R1 update pad_oe cleared", 32'(pad_oe), 32'h0);
        extest_mode = 1'b0;

        // R2 R3 R7 R8: vector table
        sample_mode = 1'b1;
        for (int k = 0; k < NV; k++) begin
            {pad_in, core_oe, core_out} = VEC[k];
            #1;
            check("R7 pad_out from core", 32'(pad_out), 32'(core_out));
            check("R7 pad_oe from core", 32'(pad_oe), 32'(core_oe));
            check("R8 core_in from pad", 32'(core_in), 32'(pad_in));
            strobe_capture();
            shift_word('0, got);
            check("R2 R3 captured order", 32'(got), 32'(expect_cap(pad_in, core_oe, core_out)));
        end

        // R4: chain length
        shift_word(12'hC35, got);
        shift_word('0, got);
        check("R4 length round trip", 32'(got), 32'hC35);

        // R10: preload under sample, pads stay on core
        core_out = 4'h3; core_oe = 4'h5;
        shift_word(pre_w, got);
        strobe_update();
        check("R10 pads on core after preload", 32'({pad_out, pad_oe}), 32'({4'h3, 4'h5}));
        sample_mode = 1'b0;
        extest_mode = 1'b1;
        #1;
        check("R10 R6 preloaded pad_out", 32'(pad_out), 32'(out_bits(pre_w)));
        check("R10 R6 preloaded pad_oe", 32'(pad_oe), 32'(oe_bits(pre_w)));

        // R5: shifting in extest does not move the pads
        shift_word(new_w, got);
        check("R5 pad_out held while shifting", 32'(pad_out), 32'(out_bits(pre_w)));
        check("R5 pad_oe held while shifting", 32'(pad_oe), 32'(oe_bits(pre_w)));
        strobe_update();
        check("R5 pad_out after update", 32'(pad_out), 32'(out_bits(new_w)));
        check("R5 pad_oe after update", 32'(pad_oe), 32'(oe_bits(new_w)));

        // R6: core changes ignored under extest
        core_out = ~core_out; core_oe = ~core_oe;
        #1;
        check("R6 pad_out ignores core", 32'(pad_out), 32'(out_bits(new_w)));
        check("R8 core_in in extest", 32'(core_in), 32'(pad_in));

        // R9: strobes ignored with no mode selected
        extest_mode = 1'b0;
        pad_in = ~pad_in;
        strobe_capture();
        scan_in = 1'b1;
        shift_en = 1'b1; repeat (5) tick(); shift_en = 1'b0;
        scan_in = 1'b0;
        strobe_update();
        check("R9 R7 pads on core when idle", 32'(pad_out), 32'(core_out));
        extest_mode = 1'b1;
        #1;
        check("R9 update stage kept", 32'({pad_out, pad_oe}), 32'({out_bits(new_w), oe_bits(new_w)}));
        extest_mode = 1'b0;
        sample_mode = 1'b1;
        shift_word('0, got);
        check("R9 shift stage kept", 32'(got), 32'(new_w));

        // R1: reset in the middle of external test
        sample_mode = 1'b0;
        extest_mode = 1'b1;
        rst_n = 1'b0;
        tick();
        check("R1 mid-run reset pads", 32'({pad_out, pad_oe}), 32'h0);
        rst_n = 1'b1;
        extest_mode = 1'b0;
        tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule